// File: doc/BRIEF.md
# Broadcast-Stream Conditional Execution Core

This block is an 8-bit processing core that sits on a shared, free-running 32-bit instruction stream. The stream is produced elsewhere and is seen by many cores at once, so a core can never stall it or redirect it. Every clock cycle one instruction word arrives, and the core either executes it or lets it pass unused. Control flow is therefore expressed by skipping. A skip instruction that finds its condition true puts the core to sleep and remembers a 4-bit label. The core then lets every following word pass until a wake word carrying the same label arrives. That wake word is executed.

The datapath takes operand A from one of sixteen working registers. Operand B is chosen from a register, the immediate field, a 128-byte local memory, the 8-bit sample input or the previous result. The ALU saturates on add and subtract and produces zero, negative and carry flags. A destination mask lets a single instruction write its result to several places in the same cycle: the A register, a second register, a memory byte and the data output. A start-of-program pulse forces the core awake. A wake label that never appears therefore costs at most the rest of one program pass.

Top module: `skip_core`

## Requirements
- R1: Instruction word layout: [31:28] opcode, [27:24] A register index n selecting register R(n+1), [23:20] B source, [19:12] immediate/address byte, [11:8] destination mask, [7:4] control code, [3:0] label. Opcodes: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shift left, 6 shift right (shift amount B[2:0]), 7 absolute difference, 8 compare, 9 pass B, 15 no operation (10 to 14 behave as no operation).
- R2: Add saturates to 255 on overflow and subtract saturates to 0 on underflow; otherwise they give the exact sum or difference.
- R3: And, or, xor, shifts, absolute difference and pass B give their arithmetic results; compare puts operand A on the result.
- R4: B source codes: 0 register R(imm[3:0]+1), 1 immediate byte, 2 local memory byte at imm[6:0], 3 sample input, 4 previous result; other codes give 0.
- R5: Destination mask bits, all honoured in the same cycle: bit0 writes the A register, bit1 writes memory at imm[6:0], bit2 writes data_out, bit3 writes register R(imm[3:0]+1).
- R6: Every executed instruction other than a no operation sets the flags. Z is set when the result is zero and N copies result bit 7. C is the carry of an add and the borrow of a subtract or absolute difference, and is 0 for the other operations. Compare sets all three flags from A minus B. A no operation changes neither the flags, result_bus nor data_out.
- R7: Control codes 1 to 5 are skips that test the flags left by the previous instruction: 1 Z, 2 not Z, 3 N, 4 C, 5 always. The skip instruction's own operation executes. When the test is true, the core sleeps with the instruction's label saved. When it is false, the core stays awake.
- R8: While asleep, an instruction that does not wake the core performs no register, memory or output write, and result_bus and data_out hold their values.
- R9: Control code 6 (wake) whose label equals the saved label clears sleep, and that instruction executes. A wake with a different label is ignored while asleep. A wake seen while awake executes as an ordinary instruction.
- R10: An instruction presented with prog_start high always executes and leaves the core awake, unless it is itself a skip whose test is true.
- R11: After reset, result_bus, data_out, all registers, the memory and the flags are zero and the core is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | 32 | Broadcast instruction word, one per cycle |
| prog_start | input | 1 | Marks the first word of a program pass |
| sample_in | input | 8 | Sample value usable as operand B |
| result_bus | output | 8 | Result of the last executed operation |
| data_out | output | 8 | Data output written through the destination mask |

## Verification
Two things can fall into the same cycle and are checked for their interaction. The first pairing is a skip and its own operation. The bench gives skip words a write to data_out and expects that write to land even though the core falls asleep on that edge. The second pairing is a wake word arriving while asleep. The bench checks that a wake with the saved label executes in the cycle that clears sleep, that one with a foreign label is dropped, and that a program-start word executes over a mismatched label. Memory written during sleep is read back after waking to confirm nothing landed.

// File: rtl/skip_pkg.sv
package skip_pkg;
    localparam int DATA_W = 8;

    localparam logic [3:0] OP_ADD   = 4'd0;
    localparam logic [3:0] OP_SUB   = 4'd1;
    localparam logic [3:0] OP_AND   = 4'd2;
    localparam logic [3:0] OP_OR    = 4'd3;
    localparam logic [3:0] OP_XOR   = 4'd4;
    localparam logic [3:0] OP_SHL   = 4'd5;
    localparam logic [3:0] OP_SHR   = 4'd6;
    localparam logic [3:0] OP_ABSD  = 4'd7;
    localparam logic [3:0] OP_CMP   = 4'd8;
    localparam logic [3:0] OP_PASSB = 4'd9;

    localparam logic [3:0] BS_REG  = 4'd0;
    localparam logic [3:0] BS_IMM  = 4'd1;
    localparam logic [3:0] BS_MEM  = 4'd2;
    localparam logic [3:0] BS_SMP  = 4'd3;
    localparam logic [3:0] BS_PREV = 4'd4;

    localparam logic [3:0] CT_NONE = 4'd0;
    localparam logic [3:0] CT_SKZ  = 4'd1;
    localparam logic [3:0] CT_SKNZ = 4'd2;
    localparam logic [3:0] CT_SKN  = 4'd3;
    localparam logic [3:0] CT_SKC  = 4'd4;
    localparam logic [3:0] CT_SKA  = 4'd5;
    localparam logic [3:0] CT_WAKE = 4'd6;

    typedef struct packed {
        logic [3:0] op;
        logic [3:0] areg;
        logic [3:0] bsel;
        logic [7:0] imm;
        logic [3:0] dmask;
        logic [3:0] ctrl;
        logic [3:0] tag;
    } instr_t;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
    } flags_t;
endpackage

// File: rtl/skip_alu.sv
module skip_alu
    import skip_pkg::*;
(
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output flags_t            fl,
    output logic              upd
);
    localparam int SHW = $clog2(DATA_W);

    logic [DATA_W:0]   sum;
    logic [DATA_W:0]   diff;
    logic [DATA_W:0]   rdiff;
    logic              borrow;
    logic [SHW-1:0]    sh;

    always_comb begin
        sum    = {1'b0, a} + {1'b0, b};
        diff   = {1'b0, a} - {1'b0, b};
        rdiff  = {1'b0, b} - {1'b0, a};
        borrow = diff[DATA_W];
        sh     = b[SHW-1:0];
        y      = a;
        upd    = 1'b1;
        fl.c   = 1'b0;
        case (op)
            OP_ADD: begin
                y    = sum[DATA_W] ? '1 : sum[DATA_W-1:0];
                fl.c = sum[DATA_W];
            end
            OP_SUB: begin
                y    = borrow ? '0 : diff[DATA_W-1:0];
                fl.c = borrow;
            end
            OP_AND:   y = a & b;
            OP_OR:    y = a | b;
            OP_XOR:   y = a ^ b;
            OP_SHL:   y = a << sh;
            OP_SHR:   y = a >> sh;
            OP_ABSD: begin
                y    = borrow ? rdiff[DATA_W-1:0] : diff[DATA_W-1:0];
                fl.c = borrow;
            end
            OP_CMP: begin
                y    = a;
                fl.c = borrow;
            end
            OP_PASSB: y = b;
            default:  upd = 1'b0;
        endcase
        if (op == OP_CMP) begin
            fl.z = (diff[DATA_W-1:0] == '0);
            fl.n = diff[DATA_W-1];
        end else begin
            fl.z = (y == '0);
            fl.n = y[DATA_W-1];
        end
    end
endmodule

// File: rtl/skip_sleep_ctl.sv
module skip_sleep_ctl
    import skip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exec_en,
    input  logic [3:0] ctrl,
    input  logic [3:0] tag,
    input  flags_t     flags,
    output logic       asleep,
    output logic [3:0] saved_tag
);
    typedef struct packed {
        logic       asleep;
        logic [3:0] tag;
    } slp_t;

    slp_t st_d, st_q;
    logic cond;

    always_comb begin
        case (ctrl)
            CT_SKZ:  cond = flags.z;
            CT_SKNZ: cond = !flags.z;
            CT_SKN:  cond = flags.n;
            CT_SKC:  cond = flags.c;
            CT_SKA:  cond = 1'b1;
            default: cond = 1'b0;
        endcase
        st_d = st_q;
        if (exec_en) begin
            st_d.asleep = cond;
            if (cond) st_d.tag = tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign asleep    = st_q.asleep;
    assign saved_tag = st_q.tag;
endmodule

// File: rtl/skip_store.sv
module skip_store
    import skip_pkg::*;
#(
    parameter int NREG      = 16,
    parameter int MEM_DEPTH = 128,
    localparam int IW = $clog2(NREG),
    localparam int AW = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     ra_idx,
    input  logic [IW-1:0]     rb_idx,
    input  logic [AW-1:0]     maddr,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    output logic [DATA_W-1:0] mem_data,
    input  logic              we_a,
    input  logic              we_b,
    input  logic              we_m,
    input  logic [DATA_W-1:0] wdata
);
    typedef struct packed {
        logic [MEM_DEPTH-1:0][DATA_W-1:0] mem;
        logic [NREG-1:0][DATA_W-1:0]      rf;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_a) st_d.rf[ra_idx] = wdata;
        if (we_b) st_d.rf[rb_idx] = wdata;
        if (we_m) st_d.mem[maddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ra_data  = st_q.rf[ra_idx];
    assign rb_data  = st_q.rf[rb_idx];
    assign mem_data = st_q.mem[maddr];
endmodule

// File: rtl/skip_core.sv
module skip_core
    import skip_pkg::*;
#(
    parameter int NREG      = 16,
    parameter int MEM_DEPTH = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] instr,
    input  logic        prog_start,
    input  logic [7:0]  sample_in,
    output logic [7:0]  result_bus,
    output logic [7:0]  data_out
);
    localparam int IW = $clog2(NREG);
    localparam int AW = $clog2(MEM_DEPTH);

    typedef struct packed {
        flags_t            flags;
        logic [DATA_W-1:0] result;
        logic [DATA_W-1:0] dout;
    } core_t;

    core_t core_d, core_q;
    instr_t ins;

    logic [DATA_W-1:0] a_val, b_val, rb_data, mem_data, alu_y;
    flags_t            alu_fl;
    logic              alu_upd;
    logic              asleep, tag_hit, exec_en, go;
    logic [3:0]        saved_tag;
    logic              rf_we_a, rf_we_b, mem_we, out_we;

    assign ins = instr_t'(instr);

    skip_store #(.NREG(NREG), .MEM_DEPTH(MEM_DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (ins.areg[IW-1:0]),
        .rb_idx   (ins.imm[IW-1:0]),
        .maddr    (ins.imm[AW-1:0]),
        .ra_data  (a_val),
        .rb_data  (rb_data),
        .mem_data (mem_data),
        .we_a     (rf_we_a),
        .we_b     (rf_we_b),
        .we_m     (mem_we),
        .wdata    (alu_y)
    );

    always_comb begin
        case (ins.bsel)
            BS_REG:  b_val = rb_data;
            BS_IMM:  b_val = ins.imm;
            BS_MEM:  b_val = mem_data;
            BS_SMP:  b_val = sample_in;
            BS_PREV: b_val = core_q.result;
            default: b_val = '0;
        endcase
    end

    skip_alu u_alu (
        .op  (ins.op),
        .a   (a_val),
        .b   (b_val),
        .y   (alu_y),
        .fl  (alu_fl),
        .upd (alu_upd)
    );

    skip_sleep_ctl u_sleep (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_en   (exec_en),
        .ctrl      (ins.ctrl),
        .tag       (ins.tag),
        .flags     (core_q.flags),
        .asleep    (asleep),
        .saved_tag (saved_tag)
    );

    always_comb begin
        tag_hit = (ins.ctrl == CT_WAKE) && (ins.tag == saved_tag);
        exec_en = !asleep || prog_start || tag_hit;
        go      = exec_en && alu_upd;
        rf_we_a = go && ins.dmask[0];
        mem_we  = go && ins.dmask[1];
        out_we  = go && ins.dmask[2];
        rf_we_b = go && ins.dmask[3];

        core_d = core_q;
        if (go) begin
            core_d.flags  = alu_fl;
            core_d.result = alu_y;
        end
        if (out_we) core_d.dout = alu_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign result_bus = core_q.result;
    assign data_out   = core_q.dout;
endmodule

// File: rtl/skip_core_chk.sv
module skip_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr,
    input logic        prog_start,
    input logic [7:0]  result_bus,
    input logic [7:0]  data_out,
    input logic        asleep,
    input logic        exec_en,
    input logic [7:0]  b_val,
    input logic        rf_we_a,
    input logic        rf_we_b,
    input logic        mem_we,
    input logic        out_we
);
    logic is_skip;
    assign is_skip = (instr[7:4] >= 4'd1) && (instr[7:4] <= 4'd5);

    // R8
    sleep_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |-> !(rf_we_a || rf_we_b || mem_we || out_we));

    // R8
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> ($stable(result_bus) && $stable(data_out)));

    // R10
    start_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start && !is_skip) |=> !asleep);

    // R7
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> ($past(exec_en) && $past(is_skip)));

    // R2
    add_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && instr[31:28] == 4'd0) |=> (result_bus >= $past(b_val)));

    // R10
    start_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> exec_en);
endmodule

bind skip_core skip_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr      (instr),
    .prog_start (prog_start),
    .result_bus (result_bus),
    .data_out   (data_out),
    .asleep     (asleep),
    .exec_en    (exec_en),
    .b_val      (b_val),
    .rf_we_a    (rf_we_a),
    .rf_we_b    (rf_we_b),
    .mem_we     (mem_we),
    .out_we     (out_we)
);

// File: tb/sim_skip_core.sv
module sim_skip_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        prog_start = 1'b0;
    logic [7:0]  sample_in = '0;
    logic [7:0]  result_bus, data_out;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 0;

    skip_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr      (instr),
        .prog_start (prog_start),
        .sample_in  (sample_in),
        .result_bus (result_bus),
        .data_out   (data_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] ar,
        input logic [3:0] bs, input logic [7:0] imm, input logic [3:0] dm,
        input logic [3:0] ct, input logic [3:0] tg);
        return {op, ar, bs, imm, dm, ct, tg};
    endfunction

    // B source immediate, pass B, optional data_out write and control
    function automatic logic [31:0] pimm(input logic [7:0] v, input logic [3:0] dm,
        input logic [3:0] ct, input logic [3:0] tg);
        return mk(4'd9, 4'd0, 4'd1, v, dm, ct, tg);
    endfunction

    task automatic issue(input logic [31:0] w, input logic ps = 1'b0);
        @(negedge clk);
        instr      = w;
        prog_start = ps;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        chk("R11 result after reset", result_bus, 8'h00);
        chk("R11 data_out after reset", data_out, 8'h00);
        issue(mk(4'd9, 4'd0, 4'd0, 8'd4, 4'b0000, 4'd0, 4'd0));
        chk("R11 register R5 after reset", result_bus, 8'h00);
        issue(mk(4'd9, 4'd0, 4'd2, 8'd90, 4'b0000, 4'd0, 4'd0));
        chk("R11 memory after reset", result_bus, 8'h00);
    endtask

    task automatic t_arith;
        issue(mk(4'd9, 4'd0, 4'd1, 8'd200, 4'b0001, 4'd0, 4'd0));
        chk("R3 pass B into R1", result_bus, 8'd200);
        issue(mk(4'd0, 4'd0, 4'd1, 8'd100, 4'b0100, 4'd0, 4'd0));
        chk("R2 add saturates", result_bus, 8'd255);
        chk("R5 data_out from add", data_out, 8'd255);
        issue(mk(4'd0, 4'd0, 4'd1, 8'd50, 4'b0000, 4'd0, 4'd0));
        chk("R2 add exact", result_bus, 8'd250);
        issue(mk(4'd9, 4'd1, 4'd1, 8'd10, 4'b0001, 4'd0, 4'd0));
        issue(mk(4'd1, 4'd1, 4'd1, 8'd20, 4'b0000, 4'd0, 4'd0));
        chk("R2 sub saturates to zero", result_bus, 8'd0);
        issue(mk(4'd1, 4'd1, 4'd1, 8'd3, 4'b0000, 4'd0, 4'd0));
        chk("R2 sub exact", result_bus, 8'd7);
    endtask

    task automatic t_logic;
        issue(mk(4'd9, 4'd2, 4'd1, 8'hF0, 4'b0001, 4'd0, 4'd0));
        issue(mk(4'd2, 4'd2, 4'd1, 8'h3C, 4'b0000, 4'd0, 4'd0));
        chk("R3 and", result_bus, 8'h30);
        issue(mk(4'd3, 4'd2, 4'd1, 8'h3C, 4'b0000, 4'd0, 4'd0));
        chk("R3 or", result_bus, 8'hFC);
        issue(mk(4'd4, 4'd2, 4'd1, 8'h3C, 4'b0000, 4'd0, 4'd0));
        chk("R3 xor", result_bus, 8'hCC);
        issue(mk(4'd9, 4'd3, 4'd1, 8'h81, 4'b0001, 4'd0, 4'd0));
        issue(mk(4'd5, 4'd3, 4'd1, 8'd1, 4'b0000, 4'd0, 4'd0));
        chk("R3 shift left", result_bus, 8'h02);
        issue(mk(4'd6, 4'd3, 4'd1, 8'd3, 4'b0000, 4'd0, 4'd0));
        chk("R3 shift right", result_bus, 8'h10);
        issue(mk(4'd9, 4'd4, 4'd1, 8'd10, 4'b0001, 4'd0, 4'd0));
        issue(mk(4'd7, 4'd4, 4'd1, 8'd30, 4'b0000, 4'd0, 4'd0));
        chk("R3 absdiff A<B", result_bus, 8'd20);
        issue(mk(4'd7, 4'd4, 4'd1, 8'd3, 4'b0000, 4'd0, 4'd0));
        chk("R3 absdiff A>B", result_bus, 8'd7);
        issue(mk(4'd8, 4'd4, 4'd1, 8'd99, 4'b0000, 4'd0, 4'd0));
        chk("R3 compare passes A", result_bus, 8'd10);
        issue(mk(4'd9, 4'd12, 4'd0, 8'd0, 4'b0000, 4'd0, 4'd0));
        chk("R1 A index 12 unused register", result_bus, 8'd200);
    endtask

    task automatic t_bsrc;
        sample_in = 8'h5A;
        issue(mk(4'd9, 4'd0, 4'd3, 8'd0, 4'b0000, 4'd0, 4'd0));
        chk("R4 sample source", result_bus, 8'h5A);
        issue(mk(4'd0, 4'd4, 4'd1, 8'd7, 4'b0010, 4'd0, 4'd0));
        issue(mk(4'd9, 4'd0, 4'd2, 8'd7, 4'b0000, 4'd0, 4'd0));
        chk("R4 memory source", result_bus, 8'd17);
        issue(mk(4'd0, 4'd4, 4'd0, 8'd2, 4'b0000, 4'd0, 4'd0));
        chk("R4 register source", result_bus, 8'd250);
        issue(mk(4'd9, 4'd0, 4'd4, 8'd0, 4'b0000, 4'd0, 4'd0));
        chk("R4 previous result source", result_bus, 8'd250);
        issue(mk(4'd9, 4'd0, 4'd9, 8'd55, 4'b0000, 4'd0, 4'd0));
        chk("R4 unused source gives zero", result_bus, 8'd0);
    endtask

    task automatic t_multi;
        issue(mk(4'd9, 4'd5, 4'd1, 8'h33, 4'b1111, 4'd0, 4'd0));
        chk("R5 data_out write", data_out, 8'h33);
        issue(mk(4'd9, 4'd0, 4'd2, 8'h33, 4'b0000, 4'd0, 4'd0));
        chk("R5 memory write", result_bus, 8'h33);
        issue(mk(4'd9, 4'd0, 4'd0, 8'd5, 4'b0000, 4'd0, 4'd0));
        chk("R5 A register write", result_bus, 8'h33);
        issue(mk(4'd9, 4'd0, 4'd0, 8'd3, 4'b0000, 4'd0, 4'd0));
        chk("R5 second register write", result_bus, 8'h33);
    endtask

    task automatic t_skip;
        issue(pimm(8'h00, 4'b0000, 4'd0, 4'd0));
        issue(pimm(8'h11, 4'b0100, 4'd1, 4'd5));
        chk("R7 skip primary executes", data_out, 8'h11);
        issue(pimm(8'h22, 4'b0100, 4'd0, 4'd0));
        chk("R8 asleep output held", data_out, 8'h11);
        chk("R8 asleep result held", result_bus, 8'h11);
        issue(pimm(8'h33, 4'b0100, 4'd6, 4'd3));
        chk("R9 foreign label ignored", data_out, 8'h11);
        issue(pimm(8'h44, 4'b0010, 4'd0, 4'd0));
        issue(pimm(8'h55, 4'b0100, 4'd6, 4'd5));
        chk("R9 matching wake executes", data_out, 8'h55);
        issue(mk(4'd9, 4'd0, 4'd2, 8'h44, 4'b0000, 4'd0, 4'd0));
        chk("R8 no memory write asleep", result_bus, 8'h00);
        issue(pimm(8'h66, 4'b0000, 4'd2, 4'd4));
        issue(pimm(8'h77, 4'b0100, 4'd0, 4'd0));
        chk("R7 false test stays awake", data_out, 8'h77);
        issue(pimm(8'h12, 4'b0100, 4'd6, 4'd9));
        chk("R9 wake while awake executes", data_out, 8'h12);
    endtask

    task automatic t_flags;
        issue(pimm(8'h80, 4'b0000, 4'd0, 4'd0));
        issue(mk(4'd15, 4'd0, 4'd1, 8'h00, 4'b0100, 4'd0, 4'd0));
        chk("R6 no-op keeps data_out", data_out, 8'h12);
        chk("R6 no-op keeps result", result_bus, 8'h80);
        issue(pimm(8'h01, 4'b0000, 4'd3, 4'd2));
        issue(pimm(8'h02, 4'b0100, 4'd0, 4'd0));
        chk("R6 negative flag causes skip", data_out, 8'h12);
        issue(pimm(8'h03, 4'b0100, 4'd6, 4'd2));
        chk("R9 wake after N skip", data_out, 8'h03);
        issue(mk(4'd0, 4'd0, 4'd1, 8'd100, 4'b0000, 4'd0, 4'd0));
        issue(pimm(8'h00, 4'b0000, 4'd4, 4'd1));
        issue(pimm(8'h04, 4'b0100, 4'd0, 4'd0));
        chk("R6 carry flag causes skip", data_out, 8'h03);
        issue(pimm(8'h05, 4'b0100, 4'd6, 4'd1));
        chk("R9 wake after C skip", data_out, 8'h05);
        issue(pimm(8'h01, 4'b0000, 4'd0, 4'd0));
        issue(pimm(8'h00, 4'b0000, 4'd4, 4'd1));
        issue(pimm(8'h06, 4'b0100, 4'd0, 4'd0));
        chk("R6 clear carry no skip", data_out, 8'h06);
        issue(mk(4'd8, 4'd4, 4'd1, 8'd10, 4'b0000, 4'd0, 4'd0));
        issue(pimm(8'h00, 4'b0000, 4'd1, 4'd8));
        issue(pimm(8'h07, 4'b0100, 4'd0, 4'd0));
        chk("R6 compare equal sets Z", data_out, 8'h06);
        issue(pimm(8'h08, 4'b0100, 4'd6, 4'd8));
    endtask

    task automatic t_start;
        issue(pimm(8'h18, 4'b0100, 4'd5, 4'd7));
        chk("R7 skip always", data_out, 8'h18);
        issue(pimm(8'h19, 4'b0100, 4'd6, 4'd6));
        chk("R10 stuck on label mismatch", data_out, 8'h18);
        issue(pimm(8'h1A, 4'b0100, 4'd0, 4'd0), 1'b1);
        chk("R10 start word executes", data_out, 8'h1A);
        issue(pimm(8'h1B, 4'b0100, 4'd0, 4'd0));
        chk("R10 awake after start", data_out, 8'h1B);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_arith();
        t_logic();
        t_bsrc();
        t_multi();
        t_skip();
        t_flags();
        t_start();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule